// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block sits between on-chip logic running on a single clock and an external 64K x 16 static RAM that has no clock of its own. A requester presents one request per handshake: a read or write flag, a 16-bit word address, 16 bits of write data and a two-bit lane mask. The controller registers the request and plays out a strobe sequence on the memory pins. The sequence is built from whole clock cycles, and parameters set how many cycles each phase lasts. Every access ends with a one-cycle done pulse. For reads, the captured word is presented in the same cycle as the done pulse.

On the memory side the controller drives active-low chip select, write enable, output enable and one enable per byte lane, together with the address. The bidirectional data bus is split into an outgoing word, an incoming word and a drive-enable flag, and the pad cell is left to the surrounding chip. Writes keep output enable inactive from start to finish. Every read is followed by a quiet stretch with no strobe active, so the memory's drivers are off before the controller can drive the bus again. A request whose mask selects no lane completes without touching the memory.

Top module: `alc_sram_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n and mem_lb_n are all 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: A write accepted at clock edge k holds chip select and the selected lanes low with mem_dq_oe at 1 for one cycle before write enable falls. Write enable then stays low for exactly WR_PULSE_CYC cycles. After it rises, one more cycle follows with the data still driven and chip select still low. rsp_done is 1 in the cycle that begins at edge k+WR_PULSE_CYC+2.
- R3: mem_oe_n stays 1 throughout every write access.
- R4: req_mask bit 0 selects the lower lane (data bits 7:0, strobe mem_lb_n) and bit 1 selects the upper lane (bits 15:8, strobe mem_ub_n). For the whole access, the strobe of a selected lane is 0 and the strobe of an unselected lane is 1. Only selected lanes of the memory word are written.
- R5: A read accepted at edge k holds chip select, output enable and the selected lanes low for RD_ACCESS_CYC cycles, with mem_dq_oe at 0. rsp_done and rsp_rdata are valid in the cycle that begins at edge k+RD_ACCESS_CYC. Selected lanes carry the memory data and unselected lanes read as zero.
- R6: After each read, TURNAROUND_CYC cycles follow in which every strobe is 1, mem_dq_oe is 0 and req_ready is 0. The bus is never driven while output enable is low.
- R7: A request with req_mask equal to 0 never lowers chip select. Its rsp_done is 1 in the cycle after acceptance, and rsp_rdata keeps its previous value.
- R8: req_ready is 0 for as long as an access is in progress. Requests presented while req_ready is 0 are ignored and leave the memory contents unchanged.
- R9: mem_addr, the lane strobes and mem_dq_out do not change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released on the clock |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The controller is idle and takes the request at this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_mask | input | 2 | Lane select: bit 0 lower, bit 1 upper |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 2*LANE_W | Read result, valid with rsp_done after a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 2*LANE_W | Data toward the memory |
| mem_dq_in | input | 2*LANE_W | Data from the memory |
| mem_dq_oe | output | 1 | 1 while the controller drives the data bus |

## Verification
Each task counts cycles from the edge that accepts its request, and samples on the falling clock edge. Counting from 1 after acceptance, a write shows setup in cycle 1, write enable low in cycles 2 to WR_PULSE_CYC+1, the hold cycle next, and done in cycle WR_PULSE_CYC+3. A read shows output enable low in cycles 1 to RD_ACCESS_CYC, done and data in cycle RD_ACCESS_CYC+1, and ready again in cycle RD_ACCESS_CYC+TURNAROUND_CYC+1. A request with an empty mask shows done in cycle 1. The tasks compare each observation against the cycle index taken from the requirements, and do not wait for events.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_TURN
  } alc_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } alc_strobe_t;

  // Pin levels each state presents to the memory.
  function automatic alc_strobe_t strobe_of(alc_state_e s);
    alc_strobe_t r;
    r = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (s)
      ST_WSETUP: r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      ST_WPULSE: r = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
      ST_WHOLD:  r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      ST_RACC:   r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
      default:   r = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alc_cyc_timer.sv
module alc_cyc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/alc_lane_map.sv
module alc_lane_map #(
  parameter int LANES = 2
) (
  input  logic             active,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] lane_n
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i] = ~(active & mask[i]);
  end

endmodule

// File: rtl/alc_rd_capture.sv
module alc_rd_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES*LANE_W-1:0] data_out
);

  for (genvar i = 0; i < LANES; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_out[i*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        data_out[i*LANE_W +: LANE_W] <= lane_en[i] ? bus_in[i*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/alc_sram_ctrl.sv
module alc_sram_ctrl
  import alc_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int LANE_W         = 8,
  parameter int WR_PULSE_CYC   = 1,
  parameter int RD_ACCESS_CYC  = 2,
  parameter int TURNAROUND_CYC = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_mask,
  output logic                  rsp_done,
  output logic [2*LANE_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_ub_n,
  output logic                  mem_lb_n,
  output logic [2*LANE_W-1:0]   mem_dq_out,
  input  logic [2*LANE_W-1:0]   mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int MAX_A  = (WR_PULSE_CYC > RD_ACCESS_CYC) ? WR_PULSE_CYC : RD_ACCESS_CYC;
  localparam int MAX_C  = (MAX_A > TURNAROUND_CYC) ? MAX_A : TURNAROUND_CYC;
  localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  alc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q, mask_d;
  logic              done_q, done_d;
  alc_strobe_t       strobe_q, strobe_d;
  logic [LANES-1:0]  lane_n_q, lane_n_d;
  logic              accept;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              lane_active_d;
  logic              capture;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_d    = accept ? req_mask : mask_q;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_mask == '0) done_d  = 1'b1;
          else if (req_write) state_d = ST_WSETUP;
          else                state_d = ST_RACC;
        end
      end
      ST_WSETUP: state_d = ST_WPULSE;
      ST_WPULSE: if (tmr_zero) state_d = ST_WHOLD;
      ST_WHOLD: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_RACC: begin
        if (tmr_zero) begin
          state_d = ST_TURN;
          done_d  = 1'b1;
        end
      end
      ST_TURN: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Phase length loaded into the timer on every state change.
  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_WPULSE: tmr_val = CNT_W'(WR_PULSE_CYC - 1);
      ST_RACC:   tmr_val = CNT_W'(RD_ACCESS_CYC - 1);
      ST_TURN:   tmr_val = CNT_W'(TURNAROUND_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  assign capture       = (state_q == ST_RACC) && tmr_zero;
  assign strobe_d      = strobe_of(state_d);
  assign lane_active_d = state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC};

  alc_cyc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  alc_lane_map #(.LANES(LANES)) i_lane_map (
    .active (lane_active_d),
    .mask   (mask_d),
    .lane_n (lane_n_d)
  );

  alc_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) i_rd_capture (
    .clk      (clk),
    .rst_n    (srst_n),
    .capture  (capture),
    .lane_en  (mask_q),
    .bus_in   (mem_dq_in),
    .data_out (rsp_rdata)
  );

  // State and registered pin drivers.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      strobe_q <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      lane_n_q <= '1;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      strobe_q <= strobe_d;
      lane_n_q <= lane_n_d;
    end
  end

  // Request fields, loaded only when a request is taken.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  assign rsp_done   = done_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = strobe_q.cs_n;
  assign mem_we_n   = strobe_q.we_n;
  assign mem_oe_n   = strobe_q.oe_n;
  assign mem_dq_oe  = strobe_q.drive;
  assign mem_lb_n   = lane_n_q[0];
  assign mem_ub_n   = lane_n_q[1];

endmodule

// File: rtl/alc_sram_ctrl_chk.sv
module alc_sram_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [1:0]          req_mask,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [2*LANE_W-1:0] mem_dq_out,
  input logic                mem_cs_n,
  input logic                mem_we_n,
  input logic                mem_oe_n,
  input logic                mem_ub_n,
  input logic                mem_lb_n,
  input logic                mem_dq_oe
);

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n) |-> mem_oe_n); // R3

  AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_dq_oe))); // R2

  AST_DATA_HELD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n)); // R2

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |->
      ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_ub_n) && $stable(mem_lb_n))); // R9

  AST_LANES_NEED_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ub_n || !mem_lb_n) |-> !mem_cs_n); // R4

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n) |-> !mem_dq_oe); // R6

  AST_QUIET_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_cs_n && !mem_dq_oe)); // R6

  AST_EMPTY_MASK_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == 2'b00) |=> mem_cs_n); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n) |-> !req_ready); // R8

endmodule

bind alc_sram_ctrl alc_sram_ctrl_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mask   (req_mask),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_ub_n   (mem_ub_n),
  .mem_lb_n   (mem_lb_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_alc_sram_ctrl.sv
module test_alc_sram_ctrl;

  localparam int WR = 2;
  localparam int RD = 2;
  localparam int TA = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  alc_sram_ctrl #(.WR_PULSE_CYC(WR), .RD_ACCESS_CYC(RD), .TURNAROUND_CYC(TA)) i_alc_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Memory model: a write lands when write enable rises with chip select low.
  logic [15:0] mem_arr [0:255];
  logic [15:0] shadow  [0:255];

  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0 && mem_dq_oe === 1'b1) begin
      if (!mem_lb_n) mem_arr[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mem_arr[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ?
    { (!mem_ub_n ? mem_arr[mem_addr[7:0]][15:8] : 8'hEE),
      (!mem_lb_n ? mem_arr[mem_addr[7:0]][7:0]  : 8'hEE) } : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    int we_low = 0, first_we = 0, done_at = 0, oe_bad = 0, moved = 0;
    bit c1ok = 0, hold_ok = 0, rel_ok = 0;
    issue(1'b1, a, d, m);
    for (int cyc = 1; cyc <= WR + 6; cyc++) begin
      @(negedge clk);
      if (cyc == 1) c1ok = !mem_cs_n && mem_we_n && mem_dq_oe && ({mem_ub_n, mem_lb_n} == ~m);
      if (cyc == WR + 2) hold_ok = !mem_cs_n && mem_we_n && mem_dq_oe;
      if (cyc == WR + 3) rel_ok = mem_cs_n && !mem_dq_oe;
      if (!mem_we_n) begin we_low++; if (first_we == 0) first_we = cyc; end
      if (!mem_cs_n && !mem_oe_n) oe_bad++;
      if (!mem_cs_n && (mem_addr !== a || mem_dq_out !== d || {mem_ub_n, mem_lb_n} !== ~m)) moved++;
      if (rsp_done && done_at == 0) done_at = cyc;
    end
    if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
    chk(c1ok, "R2 setup cycle", c1ok, 1);
    chk(we_low == WR, "R2 write pulse length", we_low, WR);
    chk(first_we == 2, "R2 write enable start", first_we, 2);
    chk(hold_ok, "R2 data hold cycle", hold_ok, 1);
    chk(rel_ok, "R2 release after hold", rel_ok, 1);
    chk(done_at == WR + 3, "R2 done timing", done_at, WR + 3);
    chk(oe_bad == 0, "R3 output enable during write", oe_bad, 0);
    chk(moved == 0, "R9 fields stable in write", moved, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] m, input string tag);
    int oe_low = 0, done_at = 0, drv = 0;
    bit lane_ok = 0, turn_ok = 1, rdy_ok = 0;
    logic [15:0] got = '0, exp;
    exp = { (m[1] ? shadow[a[7:0]][15:8] : 8'h00), (m[0] ? shadow[a[7:0]][7:0] : 8'h00) };
    issue(1'b0, a, 16'h0, m);
    for (int cyc = 1; cyc <= RD + TA + 4; cyc++) begin
      @(negedge clk);
      if (cyc == 1) lane_ok = ({mem_ub_n, mem_lb_n} == ~m) && !mem_cs_n;
      if (!mem_oe_n) oe_low++;
      if (mem_dq_oe) drv++;
      if (rsp_done && done_at == 0) begin done_at = cyc; got = rsp_rdata; end
      if (cyc > RD && cyc <= RD + TA)
        if (!(mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !req_ready))
          turn_ok = 0;
      if (cyc == RD + TA + 1) rdy_ok = req_ready;
    end
    chk(lane_ok, "R4 read lane strobes", lane_ok, 1);
    chk(oe_low == RD, "R5 read access length", oe_low, RD);
    chk(drv == 0, "R5 no drive during read", drv, 0);
    chk(done_at == RD + 1, "R5 read done timing", done_at, RD + 1);
    chk(got == exp, {tag, " read data"}, got, exp);
    chk(turn_ok, "R6 quiet turnaround", turn_ok, 1);
    chk(rdy_ok, "R6 ready after turnaround", rdy_ok, 1);
  endtask

  task automatic do_nop(input logic wr, input logic [15:0] a);
    int cs_low = 0, done_at = 0;
    logic [15:0] prev;
    prev = rsp_rdata;
    issue(wr, a, 16'hFFFF, 2'b00);
    for (int cyc = 1; cyc <= 4; cyc++) begin
      @(negedge clk);
      if (!mem_cs_n) cs_low++;
      if (rsp_done && done_at == 0) done_at = cyc;
    end
    chk(cs_low == 0, "R7 empty mask chip select", cs_low, 0);
    chk(done_at == 1, "R7 empty mask done", done_at, 1);
    chk(rsp_rdata == prev, "R7 read data kept", rsp_rdata, prev);
  endtask

  task automatic busy_ignore(input logic [15:0] a, input logic [15:0] b);
    int rdy_hi = 0;
    issue(1'b1, a, 16'h5A5A, 2'b11);
    for (int cyc = 1; cyc <= WR + 2; cyc++) begin
      @(negedge clk);
      if (req_ready) rdy_hi++;
      req_valid = 1'b1; req_write = 1'b1; req_addr = b; req_wdata = 16'hBAD0; req_mask = 2'b11;
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    shadow[a[7:0]] = 16'h5A5A;
    chk(rdy_hi == 0, "R8 ready low while busy", rdy_hi, 0);
    do_read(b, 2'b11, "R8 ignored request");
    do_read(a, 2'b11, "R8 accepted write");
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 16'h3000 + 16'(i * 7);
      shadow[i]  = 16'h3000 + 16'(i * 7);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n, "R1 strobes idle",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 5'h1F);
    chk(!mem_dq_oe && req_ready && !rsp_done, "R1 handshake idle",
        {mem_dq_oe, req_ready, rsp_done}, 3'b010);

    do_write(16'h0010, 16'hA1B2, 2'b11);
    do_read (16'h0010, 2'b11, "R5");
    do_write(16'h0011, 16'hC3D4, 2'b01);      // R4 lower lane only
    do_read (16'h0011, 2'b11, "R4 lower lane write");
    do_write(16'hFF12, 16'hE5F6, 2'b10);      // R4 upper lane only
    do_read (16'hFF12, 2'b11, "R4 upper lane write");
    do_read (16'h0010, 2'b01, "R5 lower lane read");
    do_read (16'h0010, 2'b10, "R5 upper lane read");
    do_read (16'h0020, 2'b11, "R5 untouched word");
    do_write(16'h0010, 16'h0F0F, 2'b11);      // write right after read
    do_read (16'h0010, 2'b11, "R5 overwrite");
    do_nop(1'b1, 16'h0010);
    do_read (16'h0010, 2'b11, "R7 empty write left word");
    do_nop(1'b0, 16'h0030);
    busy_ignore(16'h0040, 16'h0041);
    finish_run();
  end

endmodule